// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block is a synchronous model of the write path of a byte-wide paged nonvolatile memory. A host writes single bytes over a simple bus that has chip enable, write enable and output enable. The first accepted byte opens a load period and fixes the page. The low address bits pick a byte slot within that page, and the upper bits name the page. Further bytes for the same page are gathered into a page buffer. A per-slot mask records which slots were touched. Each accepted byte restarts a byte-load window.

When the window runs out with no new byte, loading stops and a timed programming period begins. At the end of that period only the touched slots are copied into the backing array. The array is held in ordinary registers. During load and programming, reads still return the array's previous contents. Busy is high from the first accepted byte until programming ends. A status port reports the address of the most recent accepted byte.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, busy is 0, the read-valid flag is 0, the last-address status is 0, and every array location reads as 0.
- R2: A byte is accepted only in a cycle with chip_en=1, wr_en=1 and rd_en=0. A cycle with rd_en=1, or chip_en=0, or wr_en=0 loads nothing, leaves busy low when idle, and leaves the status unchanged.
- R3: busy becomes 1 on the clock edge that accepts the first byte, and stays 1 until the programming period ends.
- R4: A byte for the open page presented within LOAD_WIN cycles of the previous accepted byte is accepted. Acceptance restarts the window.
- R5: After LOAD_WIN clock edges with no accepted byte, loading closes and programming starts. Writes presented after that point are ignored.
- R6: Programming lasts PROG_CYC clock edges. busy falls on the edge that commits the page, which is LOAD_WIN+PROG_CYC edges after the last accepted byte.
- R7: At commit, only the slots loaded in this period are written. All other array locations keep their values.
- R8: Bytes may be loaded in any slot order. A slot written twice in one period commits the value written last.
- R9: During a load period, a write whose page field (address bits above PAGE_W) differs from the open page is ignored. It does not restart the window.
- R10: A read cycle has chip_en=1, rd_en=1 and wr_en=0. It returns the array byte at the address on dout, with dout_en=1, one cycle later. In every other cycle the next dout_en is 0 and dout is 0.
- R11: last_addr holds the full address of the most recent accepted byte.
- R12: Reads during a load or programming period return the array contents from before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Chip enable, active high |
| wr_en | input | 1 | Write enable, active high |
| rd_en | input | 1 | Output enable, active high |
| addr | input | ADDR_W | Byte address; the low PAGE_W bits select the slot, the upper bits select the page |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, 0 when not valid |
| dout_en | output | 1 | Output drive enable; when low, the bus would be high-impedance |
| busy | output | 1 | Load or programming in progress |
| last_addr | output | ADDR_W | Address of the last accepted byte |

## Verification
The bench builds the controller with a 5-bit address and 3-bit slot field, which gives four pages of eight bytes. It uses a 6-cycle load window and a 20-cycle programming time. At this size every array location can be read back after each scenario and compared with a model kept in the bench. It also makes the exact window edge and the exact busy-fall cycle cheap to reach. The gap of LOAD_WIN cycles is accepted, and the gap one cycle longer is rejected.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic [1:0] {
      PW_IDLE = 2'd0,
      PW_LOAD = 2'd1,
      PW_PROG = 2'd2
   } pw_state_e;
endpackage

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
   parameter int LOAD_WIN = 16,
   parameter int PROG_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic prog_sel,
   output logic hit
);
   localparam int MAXLIM = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
   localparam int CNT_W  = $clog2(MAXLIM + 1);

   logic [CNT_W-1:0] cnt;

   assign hit = prog_sel ? (cnt == CNT_W'(PROG_CYC - 1))
                         : (cnt == CNT_W'(LOAD_WIN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (restart)  cnt <= '0;
      else if (!hit)     cnt <= cnt + 1'b1;
   end

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_sel ? (cnt < CNT_W'(PROG_CYC)) : (cnt < CNT_W'(LOAD_WIN)));
endmodule

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf #(
   parameter int PAGE_W = 7,
   parameter int DATA_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [PAGE_W-1:0]             idx,
   input  logic [DATA_W-1:0]             wdata,
   input  logic                          clr,
   input  logic                          hold,
   output logic [(1<<PAGE_W)-1:0][DATA_W-1:0] bytes_q,
   output logic [(1<<PAGE_W)-1:0]        mask_q
);
   localparam int PSIZE = 1 << PAGE_W;

   for (genvar g = 0; g < PSIZE; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bytes_q[g] <= '0;
            mask_q[g]  <= 1'b0;
         end else if (clr) begin
            mask_q[g]  <= 1'b0;
         end else if (we && idx == PAGE_W'(g)) begin
            bytes_q[g] <= wdata;
            mask_q[g]  <= 1'b1;
         end
      end
   end

   // R8
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we && !clr |=> mask_q[$past(idx)]);
   // R5
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold && !clr |=> $stable(mask_q));
   // R7
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> mask_q == '0);
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
   parameter int ADDR_W   = 9,
   parameter int PAGE_W   = 7,
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          commit,
   input  logic [ADDR_W-PAGE_W-1:0]      commit_page,
   input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0] page_bytes,
   input  logic [(1<<PAGE_W)-1:0]        page_mask,
   input  logic                          rd_req,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [DATA_W-1:0]             rd_data,
   output logic                          rd_valid
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PSIZE = 1 << PAGE_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (commit) begin
         for (int j = 0; j < PSIZE; j++)
            if (page_mask[j]) mem[{commit_page, j[PAGE_W-1:0]}] <= page_bytes[j];
      end
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
         end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_req ? mem[rd_addr] : '0;
         end
      end
      // R10
      rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_valid |-> $past(rd_req));
   end else begin : g_rd_comb
      assign rd_valid = rd_req;
      assign rd_data  = rd_req ? mem[rd_addr] : '0;
   end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
   import pgwr_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int PAGE_W   = 7,
   parameter int DATA_W   = 8,
   parameter int LOAD_WIN = 16,
   parameter int PROG_CYC = 64,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              busy,
   output logic [ADDR_W-1:0] last_addr
);
   localparam int PG_W  = ADDR_W - PAGE_W;
   localparam int PSIZE = 1 << PAGE_W;

   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("pgwr_ctrl: PAGE_W must lie in 1..ADDR_W-1");
   end
   if (LOAD_WIN < 1 || PROG_CYC < 1) begin : g_bad_time
      $error("pgwr_ctrl: LOAD_WIN and PROG_CYC must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("pgwr_ctrl: DATA_W must be at least 1");
   end

   pw_state_e          state;
   logic [PG_W-1:0]    cur_page;
   logic [PG_W-1:0]    page_in;
   logic [PAGE_W-1:0]  idx_in;
   logic               strobe, accept, close_ld, done, hit, rd_req;
   logic [PSIZE-1:0][DATA_W-1:0] buf_bytes;
   logic [PSIZE-1:0]   buf_mask;

   assign page_in  = addr[ADDR_W-1:PAGE_W];
   assign idx_in   = addr[PAGE_W-1:0];
   assign strobe   = chip_en && wr_en && !rd_en;
   assign rd_req   = chip_en && rd_en && !wr_en;
   assign accept   = strobe && ((state == PW_IDLE) ||
                                (state == PW_LOAD && page_in == cur_page));
   assign close_ld = (state == PW_LOAD) && !accept && hit;
   assign done     = (state == PW_PROG) && hit;
   assign busy     = (state != PW_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= PW_IDLE;
         cur_page  <= '0;
         last_addr <= '0;
      end else begin
         if (accept) last_addr <= addr;
         unique case (state)
            PW_IDLE: if (accept) begin
               state    <= PW_LOAD;
               cur_page <= page_in;
            end
            PW_LOAD: if (close_ld) state <= PW_PROG;
            PW_PROG: if (done) state <= PW_IDLE;
            default: state <= PW_IDLE;
         endcase
      end
   end

   pgwr_timer #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (accept || close_ld || done || state == PW_IDLE),
      .prog_sel (state == PW_PROG),
      .hit      (hit)
   );

   pgwr_pagebuf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (accept),
      .idx     (idx_in),
      .wdata   (din),
      .clr     (done),
      .hold    (state == PW_PROG),
      .bytes_q (buf_bytes),
      .mask_q  (buf_mask)
   );

   pgwr_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                .READ_REG(READ_REG)) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit      (done),
      .commit_page (cur_page),
      .page_bytes  (buf_bytes),
      .page_mask   (buf_mask),
      .rd_req      (rd_req),
      .rd_addr     (addr),
      .rd_data     (dout),
      .rd_valid    (dout_en)
   );

   // R2
   inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(last_addr) |-> $past(chip_en && wr_en && !rd_en));
   // R3
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(chip_en && wr_en && !rd_en));
   // R6
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(state == PW_PROG));
   // R9
   page_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PW_LOAD) && strobe && (page_in != cur_page) |=> $stable(last_addr));
endmodule

// File: tb/sim_pgwr_ctrl.sv
module sim_pgwr_ctrl;
   localparam int AW = 5, PW = 3, DW = 8, LW = 6, PC = 20;
   localparam int N = 1 << AW;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, ce, we, oe;
   logic [AW-1:0] addr, last_addr;
   logic [DW-1:0] din, dout;
   logic          dout_en, busy;

   int checks = 0, fails = 0;
   logic [DW-1:0] exp_mem [N];

   pgwr_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .LOAD_WIN(LW),
               .PROG_CYC(PC), .READ_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .chip_en(ce), .wr_en(we), .rd_en(oe),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
      .busy(busy), .last_addr(last_addr));

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_raw(input int a, input int d, input bit c, input bit w, input bit o);
      ce = c; we = w; oe = o; addr = AW'(a); din = DW'(d);
      @(negedge clk);
      ce = 0; we = 0; oe = 0;
   endtask

   task automatic wr(input int a, input int d);
      wr_raw(a, d, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic rd(input int a, output logic [DW-1:0] data, output logic en);
      ce = 1; oe = 1; we = 0; addr = AW'(a);
      @(negedge clk);
      data = dout; en = dout_en;
      ce = 0; oe = 0;
   endtask

   task automatic sweep(input string req);
      logic [DW-1:0] d; logic e;
      for (int a = 0; a < N; a++) begin
         rd(a, d, e);
         chk(e && d == exp_mem[a], req, {e, d}, {1'b1, exp_mem[a]});
      end
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 1000) begin @(negedge clk); n++; end
      chk(!busy, "R6", busy, 0);
   endtask

   function automatic logic [DW-1:0] pat(input int a, input int r);
      return DW'(a * 37 + r * 11 + 5);
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [DW-1:0] d; logic e;
      rst_n = 0; ce = 0; we = 0; oe = 0; addr = '0; din = '0;
      for (int a = 0; a < N; a++) exp_mem[a] = '0;
      idle(3); rst_n = 1; idle(1);

      // R1 reset state
      chk(busy == 0, "R1", busy, 0);
      chk(dout_en == 0, "R1", dout_en, 0);
      chk(last_addr == 0, "R1", last_addr, 0);
      sweep("R1");
      idle(1);
      // R10 no read -> invalid and zero
      chk(dout_en == 0 && dout == 0, "R10", {dout_en, dout}, 0);

      // R2 inhibited write cycles
      wr_raw(9, 8'h5A, 1, 1, 1); idle(1);
      chk(busy == 0, "R2", busy, 0);
      wr_raw(9, 8'h5A, 0, 1, 0); idle(1);
      chk(busy == 0, "R2", busy, 0);
      wr_raw(9, 8'h5A, 1, 0, 0); idle(1);
      chk(busy == 0 && last_addr == 0, "R2", {busy, last_addr}, 0);
      sweep("R2");

      // Page 1, reverse order, overwrite, exact timing
      for (int i = 7; i >= 0; i--) begin
         wr(8 + i, pat(8 + i, 1));
         if (i == 7) chk(busy == 1, "R3", busy, 1);
      end
      rd(12, d, e);
      chk(e && d == 0, "R12", d, 0);
      wr(10, 8'hC3);
      chk(last_addr == 10, "R11", last_addr, 10);
      idle(LW + 1);
      rd(12, d, e);
      chk(e && d == 0 && busy, "R12", d, 0);
      idle(PC - 3);
      chk(busy == 1, "R6", busy, 1);
      idle(1);
      chk(busy == 0, "R6", busy, 0);
      for (int i = 0; i < 8; i++) exp_mem[8 + i] = pat(8 + i, 1);
      exp_mem[10] = 8'hC3;
      sweep("R8");

      // Page 2 partial with a foreign-page write
      wr(17, 8'hA1);
      wr(29, 8'h77);
      chk(last_addr == 17, "R9", last_addr, 17);
      wr(21, 8'hB2);
      chk(last_addr == 21, "R11", last_addr, 21);
      wait_idle();
      exp_mem[17] = 8'hA1; exp_mem[21] = 8'hB2;
      sweep("R9");

      // Page 0 window edge
      wr(0, 8'h11);
      idle(LW - 1);
      wr(7, 8'h22);
      chk(last_addr == 7, "R4", last_addr, 7);
      idle(LW);
      wr(3, 8'h33);
      chk(last_addr == 7 && busy, "R5", {busy, last_addr}, {1'b1, 5'd7});
      wait_idle();
      exp_mem[0] = 8'h11; exp_mem[7] = 8'h22;
      rd(7, d, e); chk(d == 8'h22, "R4", d, 8'h22);
      rd(3, d, e); chk(d == 8'h00, "R5", d, 0);
      sweep("R5");

      // Partial rewrite of a programmed page
      wr(13, 8'h5E);
      wait_idle();
      exp_mem[13] = 8'h5E;
      sweep("R7");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule